// File: doc/BRIEF.md
# Fractional-Rate System Counter

This block keeps a free-running 64-bit system time value that advances at a programmable nominal tick rate. It runs on a core clock that is faster than the tick rate and has no fixed relation to it. On each core clock that is allowed to count, a 32-bit rate fraction is added to a 32-bit phase accumulator. Each carry out of the accumulator advances the 64-bit count by one. The average tick rate is therefore `rate / 2^32` times the core clock frequency. For example, a 1 MHz tick from a 1 GHz core clock needs a rate of about 4294967.

Software uses a small register port with valid, write, address and data signals. Through it, software sets the rate, enables counting, and can ask that counting pause while an external debug-halt input is high. It can also run a request/acknowledge exchange for a frequency change. A further 32-bit register holds the nominal tick frequency for software to read, and has no effect on counting. The full count can be read at any time, in one access, as a 64-bit value. It is also driven on a dedicated output.

Top module: `sysctr_top`

## Requirements
- R1: After reset, the count, the accumulator, the rate, the nominal-frequency register and every control and status bit are zero.
- R2: While control bit 0 (enable) is clear, the count holds its value.
- R3: When enable is set for N core clocks, starting from a zero accumulator, the count grows by exactly floor(N × rate / 2^32).
- R4: From one core clock to the next, the count either stays the same or grows by exactly one.
- R5: When control bit 1 (halt on debug) and enable are set and the debug-halt input is high, the count and the accumulator do not advance, and status bit 1 reads 1. When the input falls, counting resumes.
- R6: While control bit 1 is clear, the debug-halt input has no effect on counting, and status bit 1 reads 0.
- R7: Status bit 8 (frequency-change acknowledge) becomes 1 one core clock after control bit 8 (frequency-change request) is seen set. It becomes 0 one core clock after the request is seen clear.
- R8: The nominal-frequency register (address 3) reads back the value last written to it and does not change how the count advances.
- R9: Register addresses: 0 is control, 1 is status (read-only), 2 is rate, 3 is nominal frequency, and 4 is the 64-bit count (read-only). Reads are combinational on `reg_addr`. Unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| dbg_halt_i | input | 1 | Debug-halt request from the debug logic |
| count_o | output | 64 | Current system count |

## Verification
Some properties are checked on every cycle: the count never jumps by more than one, it stays still while disabled or debug-halted, and the acknowledge follows the request with one clock of delay. The exact number of increments over a window, floor(N × rate / 2^32), depends on the whole history of the accumulator. Only the bench's scenarios show it, over rates of zero, full scale, exact powers of two and a non-dyadic 1 MHz fraction. The same holds for the nominal-frequency register having no effect, and for debug-halt being ignored when not requested.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

    localparam int CNT_W  = 64;
    localparam int FRAC_W = 32;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RATE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_NFREQ = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

    localparam int B_EN   = 0;
    localparam int B_HDBG = 1;
    localparam int B_FREQ = 8;

    typedef struct packed {
        logic freq_req;
        logic halt_dbg;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic freq_ack;
        logic dbg_halted;
    } stat_t;

    typedef struct packed {
        logic              carry;
        logic [FRAC_W-1:0] sum;
    } phase_t;

    function automatic phase_t phase_step(input logic [FRAC_W-1:0] acc,
                                          input logic [FRAC_W-1:0] rate);
        logic [FRAC_W:0] wide;
        wide = {1'b0, acc} + {1'b0, rate};
        return '{carry: wide[FRAC_W], sum: wide[FRAC_W-1:0]};
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_EN]   = c.enable;
        w[B_HDBG] = c.halt_dbg;
        w[B_FREQ] = c.freq_req;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] stat_word(input stat_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_HDBG] = s.dbg_halted;
        w[B_FREQ] = s.freq_ack;
        return w;
    endfunction

endpackage

// File: rtl/sysctr_regs.sv
module sysctr_regs
    import sysctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [FRAC_W-1:0] rate,
    output logic [REG_W-1:0]  nom_freq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            rate     <= '0;
            nom_freq <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctrl.enable   <= wr_data[B_EN];
                    ctrl.halt_dbg <= wr_data[B_HDBG];
                    ctrl.freq_req <= wr_data[B_FREQ];
                end
                A_RATE:  rate     <= wr_data[FRAC_W-1:0];
                A_NFREQ: nom_freq <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sysctr_phase.sv
module sysctr_phase
    import sysctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [FRAC_W-1:0] rate,
    output logic              tick
);
    logic [FRAC_W-1:0] acc_q;
    phase_t            nxt;

    always_comb begin
        nxt  = phase_step(acc_q, rate);
        tick = advance & nxt.carry;
    end

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (advance) acc_q <= nxt.sum;
    end
endmodule

// File: rtl/sysctr_count.sv
module sysctr_count
    import sysctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/sysctr_fc_hs.sv
module sysctr_fc_hs (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ack
);
    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= req;
    end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
    import sysctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              dbg_halt_i,
    output logic [CNT_W-1:0]  count_o
);
    ctrl_t             ctrl;
    stat_t             stat;
    logic [FRAC_W-1:0] rate;
    logic [REG_W-1:0]  nom_freq;
    logic              halted;
    logic              advance;
    logic              tick;
    logic              fc_ack;

    sysctr_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_valid & reg_write),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .ctrl     (ctrl),
        .rate     (rate),
        .nom_freq (nom_freq)
    );

    always_comb begin
        halted  = ctrl.enable & ctrl.halt_dbg & dbg_halt_i;
        advance = ctrl.enable & ~halted;
    end

    sysctr_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .rate    (rate),
        .tick    (tick)
    );

    sysctr_count u_count (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (count_o)
    );

    sysctr_fc_hs u_fc (
        .clk (clk),
        .rst (rst),
        .req (ctrl.freq_req),
        .ack (fc_ack)
    );

    always_comb begin
        stat.dbg_halted = halted;
        stat.freq_ack   = fc_ack;
        case (reg_addr)
            A_CTRL:  reg_rdata = CNT_W'(ctrl_word(ctrl));
            A_STAT:  reg_rdata = CNT_W'(stat_word(stat));
            A_RATE:  reg_rdata = CNT_W'(rate);
            A_NFREQ: reg_rdata = CNT_W'(nom_freq);
            A_COUNT: reg_rdata = count_o;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk
    import sysctr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             enable,
    input logic             halted,
    input logic             req,
    input logic             ack
);
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (count == $past(count) || count == $past(count) + CNT_W'(1)));

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(count));

    // R5
    hold_when_halted_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(count));

    // R7
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> ack);

    // R7
    ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !ack);
endmodule

bind sysctr_top sysctr_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .count  (count_o),
    .enable (ctrl.enable),
    .halted (halted),
    .req    (ctrl.freq_req),
    .ack    (fc_ack)
);

// File: tb/sysctr_top_test.sv
module sysctr_top_test;
    localparam time CLK_P = 10ns;
    localparam int  NVEC  = 6;
    // each entry: {rate[31:0], clocks[31:0]}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'd1000},
        {32'h0000_0000, 32'd50},
        {32'h8000_0000, 32'd7},
        {32'h1000_0000, 32'd100},
        {32'h0041_8937, 32'd5000},
        {32'h4000_0000, 32'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        dbg_halt_i = 1'b0;
    logic [63:0] count_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    sysctr_top uut (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dbg_halt_i(dbg_halt_i), .count_o(count_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drives at a negedge, write lands on the next posedge, returns at the following negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_window(input logic [31:0] rate, input int n);
        wr(3'd2, rate);
        wr(3'd0, 32'h1);
        repeat (n - 1) @(negedge clk);
        wr(3'd0, 32'h0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, c0, c1, expc;
        do_reset();

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 64'h0);
        rd(3'd1, v); check("R1 status", v, 64'h0);
        rd(3'd2, v); check("R1 rate", v, 64'h0);
        rd(3'd3, v); check("R1 nominal", v, 64'h0);
        rd(3'd4, v); check("R1 count", v, 64'h0);
        check("R1 count port", count_o, 64'h0);

        // R3 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] r;
            int          n;
            r = VEC[i][63:32];
            n = int'(VEC[i][31:0]);
            do_reset();
            run_window(r, n);
            expc = (64'(n) * 64'(r)) >> 32;
            rd(3'd4, v);
            check("R3 increments", v, expc);
            check("R9 count port", count_o, expc);
        end

        // R8 nominal frequency readback, no effect
        do_reset();
        wr(3'd3, 32'd1000000);
        rd(3'd3, v); check("R8 readback", v, 64'd1000000);
        run_window(32'h8000_0000, 8);
        rd(3'd4, v); check("R8 no effect on count", v, 64'd4);
        rd(3'd2, v); check("R9 rate readback", v, 64'h8000_0000);

        // R2 disabled count holds
        rd(3'd4, c0);
        repeat (20) @(negedge clk);
        rd(3'd4, c1); check("R2 hold while disabled", c1, c0);

        // R5 debug halt honoured
        wr(3'd0, 32'h3);
        dbg_halt_i = 1'b1;
        rd(3'd1, v); check("R5 halted status", v, 64'h2);
        rd(3'd4, c0);
        repeat (10) @(negedge clk);
        rd(3'd4, c1); check("R5 count frozen", c1, c0);
        dbg_halt_i = 1'b0;
        rd(3'd1, v); check("R5 status clear on resume", v, 64'h0);
        rd(3'd4, c0);
        repeat (10) @(negedge clk);
        rd(3'd4, c1); check("R5 resumes", c1 - c0, 64'd5);

        // R6 debug halt ignored without the halt bit
        wr(3'd0, 32'h1);
        dbg_halt_i = 1'b1;
        rd(3'd1, v); check("R6 status stays 0", v, 64'h0);
        rd(3'd4, c0);
        repeat (10) @(negedge clk);
        rd(3'd4, c1); check("R6 counts through dbg", c1 - c0, 64'd5);
        dbg_halt_i = 1'b0;

        // R7 frequency change handshake
        do_reset();
        wr(3'd0, 32'h100);
        rd(3'd1, v); check("R7 ack not yet", v, 64'h0);
        rd(3'd0, v); check("R9 ctrl readback", v, 64'h100);
        @(negedge clk);
        rd(3'd1, v); check("R7 ack set", v, 64'h100);
        wr(3'd0, 32'h0);
        rd(3'd1, v); check("R7 ack held one clock", v, 64'h100);
        @(negedge clk);
        rd(3'd1, v); check("R7 ack cleared", v, 64'h0);
        rd(3'd5, v); check("R9 unused address", v, 64'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule